// File: doc/BRIEF.md
# Oversampled Serial Receiver with Sticky Status Flags

This block receives asynchronous serial frames: one start bit, eight data bits sent least significant bit first, and one or two stop bits. The serial line passes through a reset-high synchronizer. A frame state machine then samples the line once on each pulse of a 16x oversampling enable, `tick16`. The design assumes a baud generator outside the block supplies that enable. Each completed frame goes to a small register file. The register file holds the received byte, a status register with three sticky flags (receive-full, framing error, overrun), and a control register with the receive enable and the stop-bit count.

Software uses single-cycle read and write strobes on a two-bit address. A flag clears only in two steps. First, a status read must see the flag at 1. A later status write must then carry 0 in that flag's bit. Either error flag stops all reception until it is cleared. The `standby` input also stops reception, and it wipes both error flags.

The frame state machine has five states: IDLE, START, DATA, STOP1 and STOP2. Its transitions are:
- IDLE to START when a tick sees the line low.
- START to DATA when the line is still low at the mid-bit sample.
- START back to IDLE when the line is high at that sample.
- DATA to STOP1 after the eighth data sample.
- STOP1 to STOP2 at the stop sample when two stop bits are set.
- STOP1 to IDLE at the stop sample when one stop bit is set.
- STOP2 to IDLE after sixteen more ticks.
- Any state to IDLE whenever the receiver is halted. The receiver is halted when enable is 0, when standby is high, or when either error flag is 1.

Top module: `uart_rx_sticky`

## Requirements
- R1: After reset, the data register (address 0), the status register (address 1) and the control register (address 2) all read as 0x00.
- R2: A start bit is accepted only if the line is still low 8 ticks after the low was detected. A low pulse shorter than that produces no frame and leaves the status register unchanged.
- R3: A frame with a high stop bit, arriving while receive-full is 0, loads its byte into the data register, least significant bit first, and sets receive-full. Receive-full is status bit 0.
- R4: A frame that completes while receive-full is 1 sets the overrun flag (status bit 2). The new byte is discarded and the data register keeps the older byte.
- R5: A frame whose stop bit samples low sets the framing-error flag (status bit 1). It loads the byte into the data register but leaves receive-full at 0.
- R6: With control bit 1 set (two stop bits), only the first stop bit is checked. A low second stop bit raises no error.
- R7: While the framing-error or the overrun flag is 1, incoming frames change neither the data register nor the status register.
- R8: A status flag clears only on a status write that carries 0 in its bit, and only after an earlier status read saw that flag at 1. Without that read the write has no effect. Writing 1 in a flag's bit leaves the flag set.
- R9: While `standby` is high, both error flags clear on the next clock edge. Receive-full is left as it is.
- R10: With control bit 0 (receive enable) at 0, no frame is received. Clearing that bit leaves the error flags unchanged.
- R11: A frame that would cause both an overrun and a framing error sets only overrun, and the data register is not updated.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| standby | input | 1 | Low-power request; halts reception and clears the error flags |
| tick16 | input | 1 | One-cycle enable at 16 times the bit rate |
| rxd | input | 1 | Serial line, idle high |
| addr | input | 2 | Register select: 0 data, 1 status, 2 control |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data for the selected register |

## Verification
The assertions rely on two input conditions. First, `tick16` never stays high on two clocks in a row. Second, `rxd` holds each bit for sixteen ticks, so the mid-bit samples land well inside each bit. The stimulus meets both conditions: it pulses `tick16` once every four clocks, and it changes `rxd` only just after a tick. Because of this, the one-tick offset from start-edge detection plus the two synchronizer cycles stays far from any bit edge. The register strobes are one cycle long, never overlap, and start outside any frame-completion window. This keeps the assertion on flag-clear causes tied to a single status write.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_START = 3'd1,
        ST_DATA  = 3'd2,
        ST_STOP1 = 3'd3,
        ST_STOP2 = 3'd4
    } rx_state_e;

    localparam logic [1:0] ADDR_DATA = 2'd0;
    localparam logic [1:0] ADDR_STAT = 2'd1;
    localparam logic [1:0] ADDR_CTRL = 2'd2;

    localparam int FLAG_FULL = 0;
    localparam int FLAG_FER  = 1;
    localparam int FLAG_OVR  = 2;
    localparam int NFLAGS    = 3;

endpackage

// File: rtl/rx_line_sync.sv
module rx_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    generate
        if (STAGES < 2) begin : g_single
            logic q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) q <= 1'b1;
                else        q <= din;
            end
            assign dout = q;
        end else begin : g_chain
            logic [STAGES-1:0] sh;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sh <= '1;
                else        sh <= {sh[STAGES-2:0], din};
            end
            assign dout = sh[STAGES-1];
        end
    endgenerate
endmodule

// File: rtl/rx_frame_fsm.sv
module rx_frame_fsm
    import uart_rx_pkg::*;
#(
    parameter int DW  = 8,
    parameter int OSR = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          halt,
    input  logic          tick,
    input  logic          rxd,
    input  logic          two_stop,
    output logic          done,
    output logic [DW-1:0] byte_out,
    output logic          stop_ok,
    output rx_state_e     state
);
    localparam int CW = $clog2(OSR);
    localparam int BW = (DW > 1) ? $clog2(DW) : 1;
    localparam logic [CW-1:0] HALF_C = CW'(OSR / 2 - 1);
    localparam logic [CW-1:0] LAST_C = CW'(OSR - 1);
    localparam logic [BW-1:0] LAST_B = BW'(DW - 1);

    rx_state_e     nxt;
    logic [CW-1:0] cnt;
    logic [BW-1:0] bit_idx;
    logic [DW-1:0] shreg;

    // next-state selection
    always_comb begin
        nxt = state;
        if (halt) begin
            nxt = ST_IDLE;
        end else if (tick) begin
            unique case (state)
                ST_IDLE:  if (!rxd) nxt = ST_START;
                ST_START: if (cnt == HALF_C) nxt = rxd ? ST_IDLE : ST_DATA;
                ST_DATA:  if (cnt == LAST_C && bit_idx == LAST_B) nxt = ST_STOP1;
                ST_STOP1: if (cnt == LAST_C) nxt = two_stop ? ST_STOP2 : ST_IDLE;
                ST_STOP2: if (cnt == LAST_C) nxt = ST_IDLE;
                default:  nxt = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // counters, shifter and frame outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt     <= '0;
            bit_idx <= '0;
            shreg   <= '0;
            done    <= 1'b0;
            stop_ok <= 1'b0;
        end else begin
            done <= 1'b0;
            if (halt) begin
                cnt     <= '0;
                bit_idx <= '0;
            end else if (tick) begin
                unique case (state)
                    ST_IDLE: cnt <= '0;
                    ST_START: begin
                        if (cnt == HALF_C) begin
                            cnt     <= '0;
                            bit_idx <= '0;
                        end else begin
                            cnt <= cnt + CW'(1);
                        end
                    end
                    ST_DATA: begin
                        if (cnt == LAST_C) begin
                            cnt     <= '0;
                            shreg   <= {rxd, shreg[DW-1:1]};
                            bit_idx <= bit_idx + BW'(1);
                        end else begin
                            cnt <= cnt + CW'(1);
                        end
                    end
                    ST_STOP1: begin
                        if (cnt == LAST_C) begin
                            cnt     <= '0;
                            done    <= 1'b1;
                            stop_ok <= rxd;
                        end else begin
                            cnt <= cnt + CW'(1);
                        end
                    end
                    ST_STOP2: cnt <= (cnt == LAST_C) ? '0 : cnt + CW'(1);
                    default:  cnt <= '0;
                endcase
            end
        end
    end

    assign byte_out = shreg;
endmodule

// File: rtl/rx_regs.sv
module rx_regs
    import uart_rx_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              standby,
    input  logic [1:0]        addr,
    input  logic              rd_en,
    input  logic              wr_en,
    input  logic [DW-1:0]     wr_data,
    input  logic              done,
    input  logic [DW-1:0]     byte_in,
    input  logic              stop_ok,
    output logic [DW-1:0]     rd_data,
    output logic [DW-1:0]     rx_data,
    output logic [NFLAGS-1:0] flags,
    output logic              rx_en,
    output logic              two_stop
);
    logic [NFLAGS-1:0] armed, set_v, clr_v;
    logic stat_rd, stat_wr, accept, load;

    assign stat_rd = rd_en && (addr == ADDR_STAT);
    assign stat_wr = wr_en && (addr == ADDR_STAT);
    assign accept  = done && !flags[FLAG_FER] && !flags[FLAG_OVR];
    assign load    = accept && !flags[FLAG_FULL];

    always_comb begin
        set_v            = '0;
        set_v[FLAG_OVR]  = accept && flags[FLAG_FULL];
        set_v[FLAG_FER]  = load && !stop_ok;
        set_v[FLAG_FULL] = load && stop_ok;
        for (int i = 0; i < NFLAGS; i++)
            clr_v[i] = stat_wr && armed[i] && !wr_data[i];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flags <= '0;
            armed <= '0;
        end else begin
            for (int i = 0; i < NFLAGS; i++) begin
                if (standby && i != FLAG_FULL) begin
                    flags[i] <= 1'b0;
                    armed[i] <= 1'b0;
                end else if (set_v[i]) begin
                    flags[i] <= 1'b1;
                    armed[i] <= 1'b0;
                end else if (clr_v[i]) begin
                    flags[i] <= 1'b0;
                    armed[i] <= 1'b0;
                end else if (stat_rd && flags[i]) begin
                    armed[i] <= 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_data  <= '0;
            rx_en    <= 1'b0;
            two_stop <= 1'b0;
        end else begin
            if (load) rx_data <= byte_in;
            if (wr_en && addr == ADDR_CTRL) begin
                rx_en    <= wr_data[0];
                two_stop <= wr_data[1];
            end
        end
    end

    always_comb begin
        unique case (addr)
            ADDR_DATA: rd_data = rx_data;
            ADDR_STAT: rd_data = DW'(flags);
            ADDR_CTRL: rd_data = DW'({two_stop, rx_en});
            default:   rd_data = '0;
        endcase
    end
endmodule

// File: rtl/uart_rx_sticky.sv
module uart_rx_sticky
    import uart_rx_pkg::*;
#(
    parameter int DW          = 8,
    parameter int OSR         = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          standby,
    input  logic          tick16,
    input  logic          rxd,
    input  logic [1:0]    addr,
    input  logic          rd_en,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    output logic [DW-1:0] rd_data
);
    logic              rxd_s, frame_done, stop_ok, rx_en, two_stop, halt;
    logic [DW-1:0]     frame_byte, rx_data;
    logic [NFLAGS-1:0] flags;
    rx_state_e         fsm_state;

    assign halt = !rx_en || standby || flags[FLAG_FER] || flags[FLAG_OVR];

    rx_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .din(rxd), .dout(rxd_s)
    );

    rx_frame_fsm #(.DW(DW), .OSR(OSR)) u_fsm (
        .clk(clk), .rst_n(rst_n), .halt(halt), .tick(tick16), .rxd(rxd_s),
        .two_stop(two_stop), .done(frame_done), .byte_out(frame_byte),
        .stop_ok(stop_ok), .state(fsm_state)
    );

    rx_regs #(.DW(DW)) u_regs (
        .clk(clk), .rst_n(rst_n), .standby(standby), .addr(addr),
        .rd_en(rd_en), .wr_en(wr_en), .wr_data(wr_data), .done(frame_done),
        .byte_in(frame_byte), .stop_ok(stop_ok), .rd_data(rd_data),
        .rx_data(rx_data), .flags(flags), .rx_en(rx_en), .two_stop(two_stop)
    );
endmodule

// File: rtl/uart_rx_sticky_chk.sv
module uart_rx_sticky_chk
    import uart_rx_pkg::*;
#(
    parameter int DW = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              standby,
    input logic              wr_en,
    input logic [1:0]        addr,
    input logic [NFLAGS-1:0] flags,
    input logic [DW-1:0]     rx_data,
    input rx_state_e         state,
    input logic              done
);
    AST_OVR_KEEPS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flags[FLAG_OVR]) |-> $stable(rx_data)); // R4

    AST_FER_NOT_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flags[FLAG_FER]) |-> !$rose(flags[FLAG_FULL])); // R5

    AST_FER_FROM_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flags[FLAG_FER]) |-> $past(done)); // R5

    AST_ERR_HALTS: assert property (@(posedge clk) disable iff (!rst_n)
        (flags[FLAG_FER] || flags[FLAG_OVR]) |=> (state == ST_IDLE)); // R7

    AST_OVR_CLEAR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flags[FLAG_OVR]) |-> ($past(standby) || $past(wr_en && addr == ADDR_STAT))); // R8

    AST_FER_CLEAR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flags[FLAG_FER]) |-> ($past(standby) || $past(wr_en && addr == ADDR_STAT))); // R10

    AST_STANDBY_WIPES: assert property (@(posedge clk) disable iff (!rst_n)
        standby |=> (!flags[FLAG_FER] && !flags[FLAG_OVR])); // R9
endmodule

bind uart_rx_sticky uart_rx_sticky_chk #(.DW(DW)) u_chk (
    .clk(clk), .rst_n(rst_n), .standby(standby), .wr_en(wr_en), .addr(addr),
    .flags(flags), .rx_data(rx_data), .state(fsm_state), .done(frame_done)
);

// File: tb/uart_rx_sticky_test.sv
module uart_rx_sticky_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       standby = 1'b0;
    logic       tick16 = 1'b0;
    logic       rxd = 1'b1;
    logic [1:0] addr = 2'd0;
    logic       rd_en = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rd_data;

    int  n_cmp = 0;
    int  n_bad = 0;
    bit  finished = 1'b0;

    typedef struct {
        logic [7:0] exp;
        string      tag;
    } item_t;
    item_t sb_q[$];

    uart_rx_sticky uut (
        .clk(clk), .rst_n(rst_n), .standby(standby), .tick16(tick16),
        .rxd(rxd), .addr(addr), .rd_en(rd_en), .wr_en(wr_en),
        .wr_data(wr_data), .rd_data(rd_data)
    );

    always #4 clk = ~clk;

    // oversample enable: one cycle high in every four
    initial begin
        forever begin
            repeat (3) @(posedge clk);
            #1 tick16 = 1'b1;
            @(posedge clk);
            #1 tick16 = 1'b0;
        end
    end

    // monitor: pops the expected item for every read strobe
    always @(negedge clk) begin
        if (rd_en) begin
            if (sb_q.size() == 0) begin
                n_bad++;
                $display("FAIL scoreboard: read %h with no expected item", rd_data);
            end else begin
                item_t it;
                it = sb_q.pop_front();
                n_cmp++;
                if (rd_data !== it.exp) begin
                    n_bad++;
                    $display("FAIL %s: read %h expected %h", it.tag, rd_data, it.exp);
                end
            end
        end
    end

    task automatic reg_wr(input logic [1:0] a, input logic [7:0] d);
        @(posedge clk); #1;
        addr = a; wr_data = d; wr_en = 1'b1;
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic rd_expect(input logic [1:0] a, input logic [7:0] e, input string tag);
        item_t it;
        it.exp = e; it.tag = tag;
        sb_q.push_back(it);
        @(posedge clk); #1;
        addr = a; rd_en = 1'b1;
        @(posedge clk); #1;
        rd_en = 1'b0;
    endtask

    task automatic wait_ticks(input int n);
        for (int k = 0; k < n; k++) begin
            do @(posedge clk); while (tick16 !== 1'b1);
        end
        #1;
    endtask

    task automatic put_bit(input logic v);
        rxd = v;
        wait_ticks(16);
    endtask

    task automatic send_frame(input logic [7:0] b, input logic stop1,
                              input bit two, input logic stop2);
        wait_ticks(1);
        put_bit(1'b0);
        for (int k = 0; k < 8; k++) put_bit(b[k]);
        put_bit(stop1);
        if (two) put_bit(stop2);
        put_bit(1'b1);
        wait_ticks(8);
    endtask

    task automatic pulse_standby();
        @(posedge clk); #1 standby = 1'b1;
        @(posedge clk); #1 standby = 1'b0;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: run did not finish, got timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (5) @(posedge clk);
        #1 rst_n = 1'b1;

        rd_expect(2'd0, 8'h00, "R1 data");
        rd_expect(2'd1, 8'h00, "R1 status");
        rd_expect(2'd2, 8'h00, "R1 control");

        reg_wr(2'd2, 8'h01);
        rd_expect(2'd2, 8'h01, "R10 enable readback");
        send_frame(8'hA5, 1'b1, 1'b0, 1'b1);
        rd_expect(2'd0, 8'hA5, "R3 data");
        rd_expect(2'd1, 8'h01, "R3 full");
        reg_wr(2'd1, 8'h00);
        rd_expect(2'd1, 8'h00, "R8 full cleared after read");

        // overrun, then write without a prior read
        send_frame(8'h11, 1'b1, 1'b0, 1'b1);
        send_frame(8'h22, 1'b1, 1'b0, 1'b1);
        reg_wr(2'd1, 8'h00);
        rd_expect(2'd1, 8'h05, "R8 write without read ignored / R4 overrun");
        rd_expect(2'd0, 8'h11, "R4 older byte kept");
        reg_wr(2'd1, 8'h04);
        rd_expect(2'd1, 8'h04, "R8 writing one keeps flag");
        send_frame(8'h33, 1'b1, 1'b0, 1'b1);
        rd_expect(2'd1, 8'h04, "R7 frozen status");
        rd_expect(2'd0, 8'h11, "R7 frozen data");
        reg_wr(2'd1, 8'h00);
        rd_expect(2'd1, 8'h00, "R8 overrun cleared");

        // framing error
        send_frame(8'h5A, 1'b0, 1'b0, 1'b1);
        rd_expect(2'd1, 8'h02, "R5 framing flag, no full");
        rd_expect(2'd0, 8'h5A, "R5 byte loaded");
        send_frame(8'h66, 1'b1, 1'b0, 1'b1);
        rd_expect(2'd1, 8'h02, "R7 frozen by framing status");
        rd_expect(2'd0, 8'h5A, "R7 frozen by framing data");

        // receive enable cleared
        reg_wr(2'd2, 8'h00);
        rd_expect(2'd1, 8'h02, "R10 disable keeps error flag");
        reg_wr(2'd1, 8'h00);
        rd_expect(2'd1, 8'h00, "R8 framing cleared");
        send_frame(8'h99, 1'b1, 1'b0, 1'b1);
        rd_expect(2'd1, 8'h00, "R10 disabled status");
        rd_expect(2'd0, 8'h5A, "R10 disabled data");

        // standby
        reg_wr(2'd2, 8'h01);
        send_frame(8'hC3, 1'b0, 1'b0, 1'b1);
        pulse_standby();
        rd_expect(2'd1, 8'h00, "R9 standby clears framing");
        rd_expect(2'd0, 8'hC3, "R5 byte loaded on framing");

        // two stop bits, second low
        reg_wr(2'd2, 8'h03);
        send_frame(8'h81, 1'b1, 1'b1, 1'b0);
        rd_expect(2'd1, 8'h01, "R6 second stop unchecked");
        rd_expect(2'd0, 8'h81, "R6 data");
        reg_wr(2'd1, 8'h00);
        rd_expect(2'd1, 8'h00, "R8 full cleared");

        // short low pulse, then a real frame
        wait_ticks(1);
        rxd = 1'b0;
        wait_ticks(4);
        rxd = 1'b1;
        wait_ticks(24);
        rd_expect(2'd1, 8'h00, "R2 glitch rejected");
        send_frame(8'h42, 1'b1, 1'b1, 1'b1);
        rd_expect(2'd0, 8'h42, "R2 data after glitch");
        rd_expect(2'd1, 8'h01, "R2 full after glitch");

        // overrun and framing on one frame
        send_frame(8'h77, 1'b0, 1'b1, 1'b1);
        rd_expect(2'd1, 8'h05, "R11 overrun wins");
        rd_expect(2'd0, 8'h42, "R11 data unchanged");
        pulse_standby();
        rd_expect(2'd1, 8'h01, "R9 standby keeps full");

        repeat (4) @(posedge clk);
        finish_run();
    end
endmodule